// File: doc/BRIEF.md
# Processor Request Illegal Address Handler

This block screens every transaction arriving from the processor bus of a node controller against a small bank of programmable memory ranges. A request whose address falls inside an enabled range is passed to the memory side unchanged. A request that hits no range is given master-abort treatment, meaning a read completes with every data bit at one and a write changes nothing. The treatment depends on the transaction type and on a standalone-system control bit. With the bit set, writes and implicit writebacks are discarded and clean-snooped reads return all ones. With the bit clear, the request is forwarded on the fabric port, tagged with the compatibility attribute code.

The block also converts fabric responses into processor completions. A master-abort status on a read yields all-ones data. The same status on a write yields an ordinary completion. Each illegal-address event in standalone mode is recorded in a pair of write-one-to-clear error registers: the first event is kept together with its address, and later events only set the second flag. Zero-length requests never leave the block. The block holds one transaction at a time, so completions always come back in request order.

Top module: `pbus_abort_screen`

## Requirements
- R1: After reset, req_ready is 1, mem_req_valid, fab_req_valid and cpl_valid are 0, and both error flags read as 0.
- R2: A nonzero-length request whose address satisfies base <= addr < limit for an enabled range appears on the memory request port with its address, type and length unchanged. An address equal to the limit, or one inside a disabled range, does not match. Range i's base sits at register index i, its limit at index NUM_RNG+i, and its enable at control bit i. The control register is at index 2*NUM_RNG.
- R3: With the standalone bit set (control bit NUM_RNG), an unmatched write (type 1) or writeback (type 2) issues nothing on the memory or fabric ports. It completes with cpl_mabort 0 and data 0.
- R4: With the standalone bit set, an unmatched read (type 0) that has req_snoop_dirty 0 completes with all data bits 1 and cpl_mabort 1.
- R5: With the standalone bit set, an unmatched read that has req_snoop_dirty 1 completes with data 0 and cpl_mabort 0.
- R6: A request of length 0 issues nothing downstream, logs no error, and completes with data 0 and cpl_mabort 0, whether or not its address matches.
- R7: With the standalone bit clear, an unmatched request is forwarded on the fabric port with fab_req_attr = 2'b11 and its address unchanged. No error is logged.
- R8: A fabric response to a forwarded read completes with all-ones data and cpl_mabort 1 when fab_rsp_mabort is 1. Otherwise it completes with fab_rsp_data and cpl_mabort 0.
- R9: A fabric response to a forwarded write completes with data 0 and cpl_mabort 0, even when fab_rsp_mabort is 1.
- R10: A standalone illegal-address event that occurs while the first-error flag (bit 0 at index 2*NUM_RNG+1) is clear sets that flag. It also stores the request address at index 2*NUM_RNG+2.
- R11: An event that occurs while the first-error flag is set leaves the flag and the stored address unchanged, and sets the second-error flag (bit 0 at index 2*NUM_RNG+3).
- R12: Writing 1 to bit 0 of an error register clears that flag. When an event and a clear reach the flag chosen for that event in the same cycle, the event wins. The first-error flag is sampled before the write to decide where the event goes.
- R13: Outputs appear two clock edges after acceptance. req_ready stays 0 from acceptance until the output handshake ends. A completion held with cpl_ready 0 keeps cpl_valid and cpl_data stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Block can accept a request |
| req_type | input | 2 | 0 read, 1 write, 2 implicit writeback |
| req_addr | input | ADDR_W | Request address |
| req_len | input | LEN_W | Request length, 0 means empty |
| req_wdata | input | DATA_W | Write data |
| req_snoop_dirty | input | 1 | Snoop result, 1 dirty, 0 clean |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory side accepts |
| mem_req_type | output | 2 | Forwarded type |
| mem_req_addr | output | ADDR_W | Forwarded address |
| mem_req_len | output | LEN_W | Forwarded length |
| mem_req_wdata | output | DATA_W | Forwarded write data |
| fab_req_valid | output | 1 | Fabric request valid |
| fab_req_ready | input | 1 | Fabric accepts |
| fab_req_type | output | 2 | Forwarded type |
| fab_req_addr | output | ADDR_W | Forwarded address |
| fab_req_len | output | LEN_W | Forwarded length |
| fab_req_wdata | output | DATA_W | Forwarded write data |
| fab_req_attr | output | 2 | Attribute, compatibility code 2'b11 |
| fab_rsp_valid | input | 1 | Fabric response valid |
| fab_rsp_ready | output | 1 | Block awaits a response |
| fab_rsp_mabort | input | 1 | Response carries master-abort status |
| fab_rsp_data | input | DATA_W | Response read data |
| cpl_valid | output | 1 | Processor completion valid |
| cpl_ready | input | 1 | Processor side takes the completion |
| cpl_data | output | DATA_W | Completion data |
| cpl_mabort | output | 1 | Read was master-aborted |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register index |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data for reg_addr |

## Verification
In standalone mode, an illegal-address event is logged on the same clock edge that ends the decision cycle. A software write-one-to-clear of an error flag can arrive on that same edge. The bench lines the two up on purpose: it accepts an unmatched write and drives the register write during the following cycle. It does this twice. With the first flag clear, the flag must still end up set and hold the new address. With the first flag set, the first flag must clear and the second must set. Both outcomes are judged by reading the error registers after the edge.

// File: rtl/pbus_abort_pkg.sv
package pbus_abort_pkg;

   typedef enum logic [1:0] {
      TXN_READ  = 2'd0,
      TXN_WRITE = 2'd1,
      TXN_IWB   = 2'd2,
      TXN_RSVD  = 2'd3
   } txn_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DECIDE,
      ST_MEM,
      ST_FAB,
      ST_WAIT,
      ST_CPL
   } seq_st_t;

   localparam logic [1:0] ATTR_COMPAT = 2'b11;

endpackage

// File: rtl/pbus_abort_rdecode.sv
module pbus_abort_rdecode #(
   parameter int NUM_RNG = 4,
   parameter int ADDR_W  = 32
) (
   input  logic [NUM_RNG*ADDR_W-1:0] base_flat,
   input  logic [NUM_RNG*ADDR_W-1:0] limit_flat,
   input  logic [NUM_RNG-1:0]        rng_en,
   input  logic [ADDR_W-1:0]         addr,
   output logic [NUM_RNG-1:0]        hit_vec,
   output logic                      hit
);

   generate
      for (genvar gi = 0; gi < NUM_RNG; gi++) begin : g_cmp
         logic [ADDR_W-1:0] lo;
         logic [ADDR_W-1:0] hi;
         assign lo = base_flat[gi*ADDR_W +: ADDR_W];
         assign hi = limit_flat[gi*ADDR_W +: ADDR_W];
         assign hit_vec[gi] = rng_en[gi] && (addr >= lo) && (addr < hi);
      end
   endgenerate

   assign hit = |hit_vec;

endmodule

// File: rtl/pbus_abort_regs.sv
module pbus_abort_regs #(
   parameter int NUM_RNG = 4,
   parameter int ADDR_W  = 32,
   parameter int REG_AW  = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      reg_wr,
   input  logic [REG_AW-1:0]         reg_addr,
   input  logic [ADDR_W-1:0]         reg_wdata,
   input  logic                      err1_flag,
   input  logic [ADDR_W-1:0]         err1_addr,
   input  logic                      err2_flag,
   output logic [NUM_RNG*ADDR_W-1:0] base_flat,
   output logic [NUM_RNG*ADDR_W-1:0] limit_flat,
   output logic [NUM_RNG-1:0]        rng_en,
   output logic                      standalone,
   output logic                      clr1,
   output logic                      clr2,
   output logic [ADDR_W-1:0]         reg_rdata
);

   localparam int CTRL_IDX = 2 * NUM_RNG;
   localparam int E1_IDX   = CTRL_IDX + 1;
   localparam int E1A_IDX  = CTRL_IDX + 2;
   localparam int E2_IDX   = CTRL_IDX + 3;

   generate
      for (genvar gi = 0; gi < NUM_RNG; gi++) begin : g_rng
         logic [ADDR_W-1:0] base_q;
         logic [ADDR_W-1:0] limit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               base_q  <= '0;
               limit_q <= '0;
            end else if (reg_wr) begin
               if (reg_addr == REG_AW'(gi))           base_q  <= reg_wdata;
               if (reg_addr == REG_AW'(NUM_RNG + gi)) limit_q <= reg_wdata;
            end
         end
         assign base_flat[gi*ADDR_W +: ADDR_W]  = base_q;
         assign limit_flat[gi*ADDR_W +: ADDR_W] = limit_q;
      end
   endgenerate

   logic [NUM_RNG-1:0] en_q;
   logic               sa_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
         sa_q <= 1'b0;
      end else if (reg_wr && reg_addr == REG_AW'(CTRL_IDX)) begin
         en_q <= reg_wdata[NUM_RNG-1:0];
         sa_q <= reg_wdata[NUM_RNG];
      end
   end

   assign rng_en     = en_q;
   assign standalone = sa_q;
   assign clr1 = reg_wr && (reg_addr == REG_AW'(E1_IDX)) && reg_wdata[0];
   assign clr2 = reg_wr && (reg_addr == REG_AW'(E2_IDX)) && reg_wdata[0];

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NUM_RNG; i++) begin
         if (reg_addr == REG_AW'(i))           reg_rdata = base_flat[i*ADDR_W +: ADDR_W];
         if (reg_addr == REG_AW'(NUM_RNG + i)) reg_rdata = limit_flat[i*ADDR_W +: ADDR_W];
      end
      if (reg_addr == REG_AW'(CTRL_IDX)) begin
         reg_rdata[NUM_RNG-1:0] = en_q;
         reg_rdata[NUM_RNG]     = sa_q;
      end
      if (reg_addr == REG_AW'(E1_IDX))  reg_rdata[0] = err1_flag;
      if (reg_addr == REG_AW'(E1A_IDX)) reg_rdata    = err1_addr;
      if (reg_addr == REG_AW'(E2_IDX))  reg_rdata[0] = err2_flag;
   end

   // control write lands in the mode bit used by the decision logic
   assert_ctrl_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == REG_AW'(CTRL_IDX)) |=> (standalone == $past(reg_wdata[NUM_RNG])));

endmodule

// File: rtl/pbus_abort_errlog.sv
module pbus_abort_errlog #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev,
   input  logic [ADDR_W-1:0] ev_addr,
   input  logic              clr1,
   input  logic              clr2,
   output logic              err1_flag,
   output logic [ADDR_W-1:0] err1_addr,
   output logic              err2_flag
);

   logic f1_q, f2_q;
   logic [ADDR_W-1:0] a1_q;
   logic to_first, to_second;

   assign to_first  = ev && !f1_q;
   assign to_second = ev && f1_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f1_q <= 1'b0;
         f2_q <= 1'b0;
         a1_q <= '0;
      end else begin
         f1_q <= to_first  || (f1_q && !clr1);
         f2_q <= to_second || (f2_q && !clr2);
         if (to_first) a1_q <= ev_addr;
      end
   end

   assign err1_flag = f1_q;
   assign err1_addr = a1_q;
   assign err2_flag = f2_q;

   assert_first_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (err1_flag && !clr1) |=> (err1_flag && $stable(err1_addr)));

   assert_second_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (err1_flag && ev) |=> err2_flag);

   assert_w1c_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (err1_flag && clr1) |=> !err1_flag);

   assert_first_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!err1_flag && ev) |=> (err1_flag && err1_addr == $past(ev_addr)));

endmodule

// File: rtl/pbus_abort_screen.sv
module pbus_abort_screen
   import pbus_abort_pkg::*;
#(
   parameter int NUM_RNG = 4,
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 64,
   parameter int LEN_W   = 4,
   localparam int REG_AW = $clog2(2 * NUM_RNG + 4)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_type,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              req_snoop_dirty,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [1:0]        mem_req_type,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [LEN_W-1:0]  mem_req_len,
   output logic [DATA_W-1:0] mem_req_wdata,
   output logic              fab_req_valid,
   input  logic              fab_req_ready,
   output logic [1:0]        fab_req_type,
   output logic [ADDR_W-1:0] fab_req_addr,
   output logic [LEN_W-1:0]  fab_req_len,
   output logic [DATA_W-1:0] fab_req_wdata,
   output logic [1:0]        fab_req_attr,
   input  logic              fab_rsp_valid,
   output logic              fab_rsp_ready,
   input  logic              fab_rsp_mabort,
   input  logic [DATA_W-1:0] fab_rsp_data,
   output logic              cpl_valid,
   input  logic              cpl_ready,
   output logic [DATA_W-1:0] cpl_data,
   output logic              cpl_mabort,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata
);

   generate
      if (NUM_RNG < 1) begin : g_bad_rng
         $error("NUM_RNG must be at least 1");
      end
      if (ADDR_W < NUM_RNG + 1) begin : g_bad_aw
         $error("ADDR_W must hold the control register fields");
      end
      if (LEN_W < 1 || DATA_W < 1) begin : g_bad_dw
         $error("LEN_W and DATA_W must be positive");
      end
   endgenerate

   // ---------------- configuration and status ----------------
   logic [NUM_RNG*ADDR_W-1:0] base_flat, limit_flat;
   logic [NUM_RNG-1:0]        rng_en, hit_vec;
   logic                      standalone, clr1, clr2;
   logic                      err1_flag, err2_flag;
   logic [ADDR_W-1:0]         err1_addr;
   logic                      dec_hit, log_ev;

   pbus_abort_regs #(.NUM_RNG(NUM_RNG), .ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .err1_flag  (err1_flag),
      .err1_addr  (err1_addr),
      .err2_flag  (err2_flag),
      .base_flat  (base_flat),
      .limit_flat (limit_flat),
      .rng_en     (rng_en),
      .standalone (standalone),
      .clr1       (clr1),
      .clr2       (clr2),
      .reg_rdata  (reg_rdata)
   );

   // ---------------- captured request ----------------
   seq_st_t           st_q, st_d;
   txn_t              cap_type;
   logic [ADDR_W-1:0] cap_addr;
   logic [LEN_W-1:0]  cap_len;
   logic [DATA_W-1:0] cap_wdata;
   logic              cap_dirty;
   logic [DATA_W-1:0] cpl_data_q, cpl_data_d;
   logic              cpl_mab_q, cpl_mab_d;

   pbus_abort_rdecode #(.NUM_RNG(NUM_RNG), .ADDR_W(ADDR_W)) u_dec (
      .base_flat  (base_flat),
      .limit_flat (limit_flat),
      .rng_en     (rng_en),
      .addr       (cap_addr),
      .hit_vec    (hit_vec),
      .hit        (dec_hit)
   );

   pbus_abort_errlog #(.ADDR_W(ADDR_W)) u_log (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev        (log_ev),
      .ev_addr   (cap_addr),
      .clr1      (clr1),
      .clr2      (clr2),
      .err1_flag (err1_flag),
      .err1_addr (err1_addr),
      .err2_flag (err2_flag)
   );

   assign req_ready = (st_q == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_type  <= TXN_READ;
         cap_addr  <= '0;
         cap_len   <= '0;
         cap_wdata <= '0;
         cap_dirty <= 1'b0;
      end else if (req_valid && req_ready) begin
         cap_type  <= txn_t'(req_type);
         cap_addr  <= req_addr;
         cap_len   <= req_len;
         cap_wdata <= req_wdata;
         cap_dirty <= req_snoop_dirty;
      end
   end

   // ---------------- sequencer ----------------
   always_comb begin
      st_d       = st_q;
      cpl_data_d = cpl_data_q;
      cpl_mab_d  = cpl_mab_q;
      log_ev     = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (req_valid) st_d = ST_DECIDE;
         end
         ST_DECIDE: begin
            if (cap_len == '0) begin
               st_d       = ST_CPL;
               cpl_data_d = '0;
               cpl_mab_d  = 1'b0;
            end else if (dec_hit) begin
               st_d = ST_MEM;
            end else if (!standalone) begin
               st_d = ST_FAB;
            end else begin
               log_ev = 1'b1;
               st_d   = ST_CPL;
               if (cap_type == TXN_READ && !cap_dirty) begin
                  cpl_data_d = '1;
                  cpl_mab_d  = 1'b1;
               end else begin
                  cpl_data_d = '0;
                  cpl_mab_d  = 1'b0;
               end
            end
         end
         ST_MEM: begin
            if (mem_req_ready) st_d = ST_IDLE;
         end
         ST_FAB: begin
            if (fab_req_ready) st_d = ST_WAIT;
         end
         ST_WAIT: begin
            if (fab_rsp_valid) begin
               st_d = ST_CPL;
               if (cap_type == TXN_READ) begin
                  cpl_mab_d  = fab_rsp_mabort;
                  cpl_data_d = fab_rsp_mabort ? '1 : fab_rsp_data;
               end else begin
                  cpl_mab_d  = 1'b0;
                  cpl_data_d = '0;
               end
            end
         end
         ST_CPL: begin
            if (cpl_ready) st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         cpl_data_q <= '0;
         cpl_mab_q  <= 1'b0;
      end else begin
         st_q       <= st_d;
         cpl_data_q <= cpl_data_d;
         cpl_mab_q  <= cpl_mab_d;
      end
   end

   // ---------------- outputs ----------------
   assign mem_req_valid = (st_q == ST_MEM);
   assign mem_req_type  = cap_type;
   assign mem_req_addr  = cap_addr;
   assign mem_req_len   = cap_len;
   assign mem_req_wdata = cap_wdata;

   assign fab_req_valid = (st_q == ST_FAB);
   assign fab_req_type  = cap_type;
   assign fab_req_addr  = cap_addr;
   assign fab_req_len   = cap_len;
   assign fab_req_wdata = cap_wdata;
   assign fab_req_attr  = ATTR_COMPAT;
   assign fab_rsp_ready = (st_q == ST_WAIT);

   assign cpl_valid  = (st_q == ST_CPL);
   assign cpl_data   = cpl_data_q;
   assign cpl_mabort = cpl_mab_q;

   // ---------------- assertions ----------------
   assert_one_path_R13: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_req_valid, fab_req_valid, cpl_valid, fab_rsp_ready}));

   assert_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid || fab_req_valid || cpl_valid) |-> !req_ready);

   assert_cpl_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_valid && !cpl_ready) |=> (cpl_valid && $stable(cpl_data) && $stable(cpl_mabort)));

   assert_allones_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_valid && cpl_mabort) |-> (&cpl_data));

   assert_mem_needs_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DECIDE && st_d == ST_MEM) |-> (|hit_vec));

   assert_no_log_fwd_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fab_req_valid |-> $stable(err1_flag));

endmodule

// File: tb/pbus_abort_screen_bench.sv
module pbus_abort_screen_bench;

   localparam int NUM_RNG = 4;
   localparam int ADDR_W  = 32;
   localparam int DATA_W  = 64;
   localparam int LEN_W   = 4;
   localparam int REG_AW  = $clog2(2 * NUM_RNG + 4);
   localparam int I_CTRL  = 2 * NUM_RNG;
   localparam int I_E1    = I_CTRL + 1;
   localparam int I_E1A   = I_CTRL + 2;
   localparam int I_E2    = I_CTRL + 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic              req_valid = 0, req_ready;
   logic [1:0]        req_type = 0;
   logic [ADDR_W-1:0] req_addr = 0;
   logic [LEN_W-1:0]  req_len = 0;
   logic [DATA_W-1:0] req_wdata = 0;
   logic              req_snoop_dirty = 0;
   logic              mem_req_valid, mem_req_ready = 1;
   logic [1:0]        mem_req_type;
   logic [ADDR_W-1:0] mem_req_addr;
   logic [LEN_W-1:0]  mem_req_len;
   logic [DATA_W-1:0] mem_req_wdata;
   logic              fab_req_valid, fab_req_ready = 1;
   logic [1:0]        fab_req_type;
   logic [ADDR_W-1:0] fab_req_addr;
   logic [LEN_W-1:0]  fab_req_len;
   logic [DATA_W-1:0] fab_req_wdata;
   logic [1:0]        fab_req_attr;
   logic              fab_rsp_valid = 0, fab_rsp_ready;
   logic              fab_rsp_mabort = 0;
   logic [DATA_W-1:0] fab_rsp_data = 0;
   logic              cpl_valid, cpl_ready = 1;
   logic [DATA_W-1:0] cpl_data;
   logic              cpl_mabort;
   logic              reg_wr = 0;
   logic [REG_AW-1:0] reg_addr = 0;
   logic [ADDR_W-1:0] reg_wdata = 0;
   logic [ADDR_W-1:0] reg_rdata;

   pbus_abort_screen #(.NUM_RNG(NUM_RNG), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W))
   u_pbus_abort_screen (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
      .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
      .req_snoop_dirty(req_snoop_dirty),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_type(mem_req_type), .mem_req_addr(mem_req_addr),
      .mem_req_len(mem_req_len), .mem_req_wdata(mem_req_wdata),
      .fab_req_valid(fab_req_valid), .fab_req_ready(fab_req_ready),
      .fab_req_type(fab_req_type), .fab_req_addr(fab_req_addr),
      .fab_req_len(fab_req_len), .fab_req_wdata(fab_req_wdata),
      .fab_req_attr(fab_req_attr),
      .fab_rsp_valid(fab_rsp_valid), .fab_rsp_ready(fab_rsp_ready),
      .fab_rsp_mabort(fab_rsp_mabort), .fab_rsp_data(fab_rsp_data),
      .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_data(cpl_data),
      .cpl_mabort(cpl_mabort),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;
   localparam logic [DATA_W-1:0] ONES = '1;

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic reg_write(input int idx, input logic [ADDR_W-1:0] d);
      @(negedge clk);
      reg_wr = 1; reg_addr = REG_AW'(idx); reg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic reg_read(input int idx, output logic [ADDR_W-1:0] d);
      reg_addr = REG_AW'(idx);
      #1;
      d = reg_rdata;
   endtask

   // issue a request; return at the negedge where the outputs have settled
   task automatic issue(input logic [1:0] t, input logic [ADDR_W-1:0] a,
                        input logic [LEN_W-1:0] l, input logic dirty);
      @(negedge clk);
      req_valid = 1; req_type = t; req_addr = a; req_len = l;
      req_snoop_dirty = dirty; req_wdata = {32'hC0DE0000, a};
      @(posedge clk);
      @(negedge clk);
      req_valid = 0;
      @(negedge clk);
   endtask

   task automatic expect_cpl(input string req, input logic [DATA_W-1:0] d, input logic mab);
      chk(req, "cpl_valid", 64'(cpl_valid), 64'd1);
      chk(req, "mem_req_valid", 64'(mem_req_valid), 64'd0);
      chk(req, "fab_req_valid", 64'(fab_req_valid), 64'd0);
      chk(req, "cpl_data", cpl_data, d);
      chk(req, "cpl_mabort", 64'(cpl_mabort), 64'(mab));
   endtask

   task automatic fab_respond(input logic mab, input logic [DATA_W-1:0] d);
      @(negedge clk);
      fab_rsp_valid = 1; fab_rsp_mabort = mab; fab_rsp_data = d;
      @(posedge clk);
      @(negedge clk);
      fab_rsp_valid = 0;
   endtask

   task automatic clear_errs();
      reg_write(I_E1, 1);
      reg_write(I_E2, 1);
   endtask

   task automatic t_reset();
      logic [ADDR_W-1:0] r;
      chk("R1", "req_ready", 64'(req_ready), 64'd1);
      chk("R1", "mem_req_valid", 64'(mem_req_valid), 64'd0);
      chk("R1", "fab_req_valid", 64'(fab_req_valid), 64'd0);
      chk("R1", "cpl_valid", 64'(cpl_valid), 64'd0);
      reg_read(I_E1, r); chk("R1", "err1 flag", 64'(r), 64'd0);
      reg_read(I_E2, r); chk("R1", "err2 flag", 64'(r), 64'd0);
   endtask

   task automatic t_config();
      logic [ADDR_W-1:0] r;
      reg_write(0, 32'h1000);
      reg_write(NUM_RNG + 0, 32'h2000);
      reg_write(1, 32'h8000);
      reg_write(NUM_RNG + 1, 32'h9000);
      reg_write(I_CTRL, 32'h11);   // range 0 enabled, standalone set
      reg_read(I_CTRL, r);
      chk("R2", "ctrl readback", 64'(r), 64'h11);
   endtask

   task automatic t_match_R2();
      issue(2'd0, 32'h1000, 4'd8, 1'b0);
      chk("R2", "mem_req_valid at base", 64'(mem_req_valid), 64'd1);
      chk("R2", "mem_req_addr", 64'(mem_req_addr), 64'h1000);
      chk("R2", "mem_req_type", 64'(mem_req_type), 64'd0);
      chk("R2", "mem_req_len", 64'(mem_req_len), 64'd8);
      chk("R2", "no cpl on hit", 64'(cpl_valid), 64'd0);
      issue(2'd1, 32'h1FFF, 4'd1, 1'b0);
      chk("R2", "mem_req_valid below limit", 64'(mem_req_valid), 64'd1);
      chk("R2", "mem_req_type write", 64'(mem_req_type), 64'd1);
   endtask

   task automatic t_drop_R3();
      logic [ADDR_W-1:0] r;
      issue(2'd1, 32'h2000, 4'd4, 1'b0);   // limit is exclusive
      expect_cpl("R3", '0, 1'b0);
      issue(2'd2, 32'h8010, 4'd4, 1'b1);   // disabled range, writeback
      expect_cpl("R3", '0, 1'b0);
      reg_read(I_E1, r);  chk("R10", "err1 flag", 64'(r), 64'd1);
      reg_read(I_E1A, r); chk("R10", "err1 addr", 64'(r), 64'h2000);
      reg_read(I_E2, r);  chk("R11", "err2 flag", 64'(r), 64'd1);
      clear_errs();
      reg_read(I_E1, r);  chk("R12", "err1 cleared", 64'(r), 64'd0);
      reg_read(I_E2, r);  chk("R12", "err2 cleared", 64'(r), 64'd0);
   endtask

   task automatic t_reads_R4_R5();
      logic [ADDR_W-1:0] r;
      issue(2'd0, 32'h0, 4'd8, 1'b0);
      expect_cpl("R4", ONES, 1'b1);
      reg_read(I_E1A, r); chk("R10", "err1 addr read", 64'(r), 64'h0);
      issue(2'd0, 32'h3000, 4'd8, 1'b1);
      expect_cpl("R5", '0, 1'b0);
      reg_read(I_E1A, r); chk("R11", "err1 addr kept", 64'(r), 64'h0);
      reg_read(I_E2, r);  chk("R11", "err2 set", 64'(r), 64'd1);
      clear_errs();
   endtask

   task automatic t_zero_R6();
      logic [ADDR_W-1:0] r;
      issue(2'd1, 32'h5000, 4'd0, 1'b0);
      expect_cpl("R6", '0, 1'b0);
      issue(2'd0, 32'h1800, 4'd0, 1'b0);   // would match, still no memory
      expect_cpl("R6", '0, 1'b0);
      issue(2'd0, 32'h5000, 4'd0, 1'b0);   // unmatched clean read, no all-ones
      expect_cpl("R6", '0, 1'b0);
      reg_read(I_E1, r); chk("R6", "no err1 log", 64'(r), 64'd0);
   endtask

   task automatic t_same_cycle_R12();
      logic [ADDR_W-1:0] r;
      // first flag clear: event and clear of first on one edge -> event wins
      @(negedge clk);
      req_valid = 1; req_type = 2'd1; req_addr = 32'h6660; req_len = 4'd2;
      @(posedge clk);
      @(negedge clk);
      req_valid = 0;
      reg_wr = 1; reg_addr = REG_AW'(I_E1); reg_wdata = 1;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 0;
      expect_cpl("R12", '0, 1'b0);
      reg_read(I_E1, r);  chk("R12", "event beats clear", 64'(r), 64'd1);
      reg_read(I_E1A, r); chk("R12", "addr captured", 64'(r), 64'h6660);
      // first flag set: event goes to second while first is cleared
      @(negedge clk);
      req_valid = 1; req_type = 2'd2; req_addr = 32'h7770; req_len = 4'd2;
      @(posedge clk);
      @(negedge clk);
      req_valid = 0;
      reg_wr = 1; reg_addr = REG_AW'(I_E1); reg_wdata = 1;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 0;
      reg_read(I_E1, r); chk("R12", "first cleared", 64'(r), 64'd0);
      reg_read(I_E2, r); chk("R12", "second set", 64'(r), 64'd1);
      clear_errs();
   endtask

   task automatic t_fabric_R7_R8_R9();
      logic [ADDR_W-1:0] r;
      reg_write(I_CTRL, 32'h01);  // standalone clear
      issue(2'd1, 32'h4000, 4'd4, 1'b0);
      chk("R7", "fab_req_valid", 64'(fab_req_valid), 64'd1);
      chk("R7", "fab_req_attr", 64'(fab_req_attr), 64'h3);
      chk("R7", "fab_req_addr", 64'(fab_req_addr), 64'h4000);
      chk("R7", "no mem", 64'(mem_req_valid), 64'd0);
      fab_respond(1'b1, 64'h55);
      expect_cpl("R9", '0, 1'b0);
      issue(2'd0, 32'h4100, 4'd8, 1'b0);
      chk("R7", "fab read forwarded", 64'(fab_req_valid), 64'd1);
      fab_respond(1'b1, 64'h1234);
      expect_cpl("R8", ONES, 1'b1);
      issue(2'd0, 32'h4200, 4'd8, 1'b0);
      fab_respond(1'b0, 64'hFEED_0000_1234);
      expect_cpl("R8", 64'hFEED_0000_1234, 1'b0);
      reg_read(I_E1, r); chk("R7", "no log when forwarding", 64'(r), 64'd0);
      reg_write(I_CTRL, 32'h11);
   endtask

   task automatic t_hold_R13();
      logic [DATA_W-1:0] d0;
      cpl_ready = 0;
      issue(2'd0, 32'h0A00, 4'd8, 1'b0);
      chk("R13", "cpl at two edges", 64'(cpl_valid), 64'd1);
      d0 = cpl_data;
      chk("R13", "req_ready low", 64'(req_ready), 64'd0);
      repeat (3) @(negedge clk);
      chk("R13", "cpl held", 64'(cpl_valid), 64'd1);
      chk("R13", "data held", cpl_data, d0);
      chk("R13", "still busy", 64'(req_ready), 64'd0);
      cpl_ready = 1;
      @(negedge clk);
      chk("R13", "cpl released", 64'(cpl_valid), 64'd0);
      chk("R13", "ready again", 64'(req_ready), 64'd1);
      clear_errs();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_config();
      t_match_R2();
      t_drop_R3();
      t_reads_R4_R5();
      t_zero_R6();
      t_same_cycle_R12();
      t_fabric_R7_R8_R9();
      t_hold_R13();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

endmodule